// File: doc/BRIEF.md
# Calendar Time Access Sequencer

This block sits between a host and a register-access port that reaches a real-time clock made of 4-bit registers. On a command it runs the whole transaction: it asserts the clock's chip enable, makes sure the clock is not in the middle of an internal update, and then reads or writes every time field as two nibbles. The host gives packed BCD bytes for seconds, minutes, hours, day, month and two-digit year, plus a weekday nibble. It gets the same fields back after a read, together with a time-valid flag and an error flag.

Before every read or write of the time, the block writes the base value to the clock's control register and reads that register back. If the busy bit is set, it drops chip enable, waits, and tries again. The number of attempts is limited. A separate initialisation command checks the oscillator-stop bit. If the oscillator has stopped, the block clears the timer register and runs an adjust cycle with its own bounded busy poll. Each command ends with a single-cycle done pulse.

The register-access port uses a request/acknowledge handshake. `regReq` stays high, with address, direction and write data held steady, until `regAck` pulses for one cycle. On a read, `regRdata` is valid in the same cycle as that pulse. If `regReq` is still high in the cycle after an acknowledge, that is a new request.

Top module: `rtc_time_sequencer`

## Requirements
- R1: After reset, `chipEn`, `regReq`, `done`, `timeValid` and `errFlag` are 0, and every time output is 0.
- R2: A get or set starts each attempt by writing the base value (default 4'h4) to the control address (default 14) and then reading that address. `regReq` is never high while `chipEn` is low.
- R3: When a control read-back shows the busy bit (default bit 1) set, `chipEn` goes low for GAP_CYCLES cycles and the attempt is repeated, for at most RETRY_LIMIT (10) attempts. If the last attempt is also busy, the command ends with `errFlag`=1 and touches no time register.
- R4: A get reads addresses ADDR_FIRST+0 through ADDR_FIRST+11 in ascending order, then the weekday address (default 12). Field order is seconds, minutes, hours, day, month, year, with ones before tens. Each ones nibble lands in bits 3:0 of the field output and each tens nibble in bits 7:4.
- R5: A set writes the same addresses in the same order. Bits 3:0 of each field byte go to the ones address, bits 7:4 go to the tens address, and `setWday` goes to the weekday address.
- R6: Every command, whether it succeeds, fails or is suppressed, produces exactly one single-cycle `done` pulse. `chipEn` is low from the cycle after the last register access.
- R7: A get while `timeValid`=0 issues no request and no chip enable, leaves the time outputs unchanged, and ends with `errFlag`=0.
- R8: A set that completes sets `timeValid`=1. A set that runs out of attempts leaves `timeValid` unchanged.
- R9: An initialisation that reads the oscillator-stop bit (default bit 3) as 0 performs only that one control read and sets `timeValid`=1.
- R10: An initialisation that reads the oscillator-stop bit as 1 clears `timeValid`. It then writes 0 to the timer address (default 13) and writes base plus the adjust bit (default bit 0, value 4'h5) to control. It polls control until busy reads 0, then writes the base value to control, and `chipEn` stays high throughout.
- R11: If all POLL_LIMIT initialisation polls read busy, the command ends with `errFlag`=1 and omits the final base write.
- R12: While `regReq` is high and `regAck` is low, the following cycle keeps `regReq` high with the same address, direction and write data.
- R13: Command inputs that arrive while a command is running are ignored. They cause no extra bus access and no extra `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initCmd | input | 1 | Start initialisation (highest priority) |
| getCmd | input | 1 | Start a time read |
| setCmd | input | 1 | Start a time write (above get) |
| setSec | input | 8 | BCD seconds to write |
| setMin | input | 8 | BCD minutes to write |
| setHour | input | 8 | BCD hours to write |
| setDay | input | 8 | BCD day to write |
| setMon | input | 8 | BCD month to write |
| setYear | input | 8 | BCD two-digit year to write |
| setWday | input | 4 | Weekday nibble to write |
| regReq | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 4 | Register address |
| regWdata | output | 4 | Write nibble |
| regAck | input | 1 | Access complete, one-cycle pulse |
| regRdata | input | 4 | Read nibble, valid with regAck |
| chipEn | output | 1 | Clock chip enable |
| curSec | output | 8 | Seconds read back |
| curMin | output | 8 | Minutes read back |
| curHour | output | 8 | Hours read back |
| curDay | output | 8 | Day read back |
| curMon | output | 8 | Month read back |
| curYear | output | 8 | Year read back |
| curWday | output | 4 | Weekday read back |
| timeValid | output | 1 | Stored time is trusted |
| errFlag | output | 1 | Last command ran out of attempts |
| done | output | 1 | Command finished, one-cycle pulse |

## Verification
The bench keeps the default RETRY_LIMIT of 10 and sets GAP_CYCLES to 3 and POLL_LIMIT to 12. With these values, both the final successful retry (nine busy replies) and total retry exhaustion (ten busy replies) fit in short runs. The initialisation poll can be driven to its limit in a dozen reads instead of a thousand, and the chip-enable gaps stay short enough that many random set/get pairs with random busy counts and random acknowledge latency fit in the run.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 2 * NIB_W;
  localparam int FIELD_CNT = 6;
  localparam int STEP_CNT  = 2 * FIELD_CNT + 1;
  localparam int STEP_W    = $clog2(STEP_CNT);
  localparam int FSEL_W    = STEP_W - 1;

  typedef enum logic [1:0] {OP_GET, OP_SET, OP_INIT} opKind_t;
  typedef enum logic [1:0] {ASEL_CTRL, ASEL_TINT, ASEL_STEP} addrSel_t;
  typedef enum logic [1:0] {WSEL_BASE, WSEL_ADJ, WSEL_ZERO, WSEL_STEP} wdSel_t;

  typedef struct packed {
    logic     latchSet;
    logic     clrStep;
    logic     incStep;
    logic     capRead;
    addrSel_t addrSel;
    wdSel_t   wdSel;
  } dpStrobe_t;
endpackage

// File: rtl/rtc_seq_dpath.sv
module rtc_seq_dpath
  import rtc_seq_pkg::*;
#(
  parameter logic [NIB_W-1:0] ADDR_FIRST = 4'd0,
  parameter logic [NIB_W-1:0] ADDR_WDAY  = 4'd12,
  parameter logic [NIB_W-1:0] ADDR_TINT  = 4'd13,
  parameter logic [NIB_W-1:0] ADDR_CTRL  = 4'd14,
  parameter logic [NIB_W-1:0] CTRL_BASE  = 4'h4,
  parameter int               ADJ_BIT    = 0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strobe,
  input  logic [FIELD_CNT-1:0][BYTE_W-1:0]   setFields,
  input  logic [NIB_W-1:0]                   setWday,
  input  logic [NIB_W-1:0]                   regRdata,
  output logic [NIB_W-1:0]                   regAddr,
  output logic [NIB_W-1:0]                   regWdata,
  output logic                               lastStep,
  output logic [FIELD_CNT-1:0][BYTE_W-1:0]   curFields,
  output logic [NIB_W-1:0]                   curWday
);
  localparam logic [NIB_W-1:0] CTRL_ADJ_VAL = CTRL_BASE | NIB_W'(1 << ADJ_BIT);
  localparam logic [STEP_W-1:0] STEP_LAST   = STEP_W'(STEP_CNT - 1);

  logic [STEP_W-1:0]                 stepIdx;
  logic [FSEL_W-1:0]                 fieldSel;
  logic                              tensSel;
  logic [FIELD_CNT-1:0][BYTE_W-1:0]  heldFields;
  logic [NIB_W-1:0]                  heldWday;
  logic [NIB_W-1:0]                  stepAddr;
  logic [NIB_W-1:0]                  stepNib;
  logic [NIB_W-1:0]                  wdayQ;

  assign fieldSel = stepIdx[STEP_W-1:1];
  assign tensSel  = stepIdx[0];
  assign lastStep = (stepIdx == STEP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strobe.clrStep) begin
      stepIdx <= '0;
    end else if (strobe.incStep) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldFields <= '0;
      heldWday   <= '0;
    end else if (strobe.latchSet) begin
      heldFields <= setFields;
      heldWday   <= setWday;
    end
  end

  // Nibble sent during the current step: ones/tens half of a field, or weekday
  always_comb begin
    stepNib = '0;
    for (int f = 0; f < FIELD_CNT; f++) begin
      if (fieldSel == FSEL_W'(f)) begin
        stepNib = tensSel ? heldFields[f][BYTE_W-1:NIB_W] : heldFields[f][NIB_W-1:0];
      end
    end
    if (lastStep) stepNib = heldWday;
  end

  assign stepAddr = lastStep ? ADDR_WDAY : (ADDR_FIRST + NIB_W'(stepIdx));

  always_comb begin
    unique case (strobe.addrSel)
      ASEL_TINT: regAddr = ADDR_TINT;
      ASEL_STEP: regAddr = stepAddr;
      default:   regAddr = ADDR_CTRL;
    endcase
  end

  always_comb begin
    unique case (strobe.wdSel)
      WSEL_ADJ:  regWdata = CTRL_ADJ_VAL;
      WSEL_ZERO: regWdata = '0;
      WSEL_STEP: regWdata = stepNib;
      default:   regWdata = CTRL_BASE;
    endcase
  end

  // One capture register per field
  for (genvar f = 0; f < FIELD_CNT; f++) begin : gField
    logic [BYTE_W-1:0] fieldQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fieldQ <= '0;
      end else if (strobe.capRead && !lastStep && (fieldSel == FSEL_W'(f))) begin
        if (tensSel) fieldQ[BYTE_W-1:NIB_W] <= regRdata;
        else         fieldQ[NIB_W-1:0]      <= regRdata;
      end
    end
    assign curFields[f] = fieldQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wdayQ <= '0;
    else if (strobe.capRead && lastStep)  wdayQ <= regRdata;
  end
  assign curWday = wdayQ;

  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= STEP_LAST);
  assert_inc_not_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incStep |-> !lastStep);
  assert_cap_on_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capRead |-> (strobe.addrSel == ASEL_STEP));
endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
  import rtc_seq_pkg::*;
#(
  parameter int RETRY_LIMIT  = 10,
  parameter int POLL_LIMIT   = 1000,
  parameter int GAP_CYCLES   = 4,
  parameter int BUSY_BIT     = 1,
  parameter int OSC_STOP_BIT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initCmd,
  input  logic             getCmd,
  input  logic             setCmd,
  input  logic             regAck,
  input  logic [NIB_W-1:0] regRdata,
  input  logic             lastStep,
  output logic             regReq,
  output logic             regWrite,
  output logic             chipEn,
  output logic             done,
  output logic             timeValid,
  output logic             errFlag,
  output dpStrobe_t        strobe
);
  localparam int RETRY_W = $clog2(RETRY_LIMIT + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W   = $clog2(GAP_CYCLES + 1);
  localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(RETRY_LIMIT - 1);
  localparam logic [POLL_W-1:0]  POLL_LAST  = POLL_W'(POLL_LIMIT - 1);
  localparam logic [GAP_W-1:0]   GAP_LAST   = GAP_W'(GAP_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CE_WAIT, S_CTRL_WR, S_CTRL_RD, S_OFF_WAIT, S_XFER,
    S_I_RD, S_I_TINT, S_I_ADJ, S_I_POLL, S_I_PWAIT, S_I_BASE, S_FINISH
  } state_t;

  state_t             state;
  opKind_t            op;
  logic [RETRY_W-1:0] retryCnt;
  logic [POLL_W-1:0]  pollCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               validR;
  logic               errR;
  logic               gapDone;
  logic               accept;
  logic               busyRd;

  assign gapDone = (gapCnt == GAP_LAST);
  assign accept  = (state == S_IDLE) && (initCmd || setCmd || getCmd);
  assign busyRd  = regRdata[BUSY_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      op       <= OP_GET;
      retryCnt <= '0;
      pollCnt  <= '0;
      gapCnt   <= '0;
      validR   <= 1'b0;
      errR     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          retryCnt <= '0;
          pollCnt  <= '0;
          gapCnt   <= '0;
          if (initCmd) begin
            op    <= OP_INIT;
            state <= S_CE_WAIT;
          end else if (setCmd) begin
            op    <= OP_SET;
            state <= S_CE_WAIT;
          end else if (getCmd) begin
            op <= OP_GET;
            if (validR) state <= S_CE_WAIT;
            else begin
              errR  <= 1'b0;
              state <= S_FINISH;
            end
          end
        end
        S_CE_WAIT: begin
          if (gapDone) begin
            gapCnt <= '0;
            state  <= (op == OP_INIT) ? S_I_RD : S_CTRL_WR;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_CTRL_WR: if (regAck) state <= S_CTRL_RD;
        S_CTRL_RD: begin
          if (regAck) begin
            if (busyRd) begin
              if (retryCnt == RETRY_LAST) begin
                errR  <= 1'b1;
                state <= S_FINISH;
              end else begin
                retryCnt <= retryCnt + 1'b1;
                state    <= S_OFF_WAIT;
              end
            end else state <= S_XFER;
          end
        end
        S_OFF_WAIT: begin
          if (gapDone) begin
            gapCnt <= '0;
            state  <= S_CE_WAIT;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_XFER: begin
          if (regAck && lastStep) begin
            errR <= 1'b0;
            if (op == OP_SET) validR <= 1'b1;
            state <= S_FINISH;
          end
        end
        S_I_RD: begin
          if (regAck) begin
            if (!regRdata[OSC_STOP_BIT]) begin
              validR <= 1'b1;
              errR   <= 1'b0;
              state  <= S_FINISH;
            end else begin
              validR <= 1'b0;
              state  <= S_I_TINT;
            end
          end
        end
        S_I_TINT: if (regAck) state <= S_I_ADJ;
        S_I_ADJ:  if (regAck) state <= S_I_POLL;
        S_I_POLL: begin
          if (regAck) begin
            if (busyRd) begin
              if (pollCnt == POLL_LAST) begin
                errR  <= 1'b1;
                state <= S_FINISH;
              end else begin
                pollCnt <= pollCnt + 1'b1;
                state   <= S_I_PWAIT;
              end
            end else state <= S_I_BASE;
          end
        end
        S_I_PWAIT: begin
          if (gapDone) begin
            gapCnt <= '0;
            state  <= S_I_POLL;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_I_BASE: begin
          if (regAck) begin
            errR  <= 1'b0;
            state <= S_FINISH;
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    regReq = 1'b0;
    unique case (state)
      S_CTRL_WR, S_CTRL_RD, S_XFER, S_I_RD, S_I_TINT, S_I_ADJ, S_I_POLL, S_I_BASE:
        regReq = 1'b1;
      default: regReq = 1'b0;
    endcase
  end

  always_comb begin
    chipEn = 1'b1;
    if (state == S_IDLE || state == S_OFF_WAIT || state == S_FINISH) chipEn = 1'b0;
  end

  assign regWrite = (state == S_CTRL_WR) || (state == S_I_TINT) || (state == S_I_ADJ) ||
                    (state == S_I_BASE)  || ((state == S_XFER) && (op == OP_SET));
  assign done      = (state == S_FINISH);
  assign timeValid = validR;
  assign errFlag   = errR;

  always_comb begin
    strobe          = '0;
    strobe.latchSet = accept && !initCmd && setCmd;
    strobe.clrStep  = accept;
    strobe.incStep  = (state == S_XFER) && regAck && !lastStep;
    strobe.capRead  = (state == S_XFER) && regAck && (op == OP_GET);
    unique case (state)
      S_I_TINT: begin strobe.addrSel = ASEL_TINT; strobe.wdSel = WSEL_ZERO; end
      S_I_ADJ:  begin strobe.addrSel = ASEL_CTRL; strobe.wdSel = WSEL_ADJ;  end
      S_XFER:   begin strobe.addrSel = ASEL_STEP; strobe.wdSel = WSEL_STEP; end
      default:  begin strobe.addrSel = ASEL_CTRL; strobe.wdSel = WSEL_BASE; end
    endcase
  end

  assert_req_needs_ce_R2: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> chipEn);
  assert_retry_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RETRY_W'(RETRY_LIMIT));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_suppressed_get_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && getCmd && !setCmd && !initCmd && !timeValid) |=> (!chipEn && !regReq));
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeValid) |-> done);
  assert_poll_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));
endmodule

// File: rtl/rtc_time_sequencer.sv
module rtc_time_sequencer
  import rtc_seq_pkg::*;
#(
  parameter int               RETRY_LIMIT  = 10,
  parameter int               POLL_LIMIT   = 1000,
  parameter int               GAP_CYCLES   = 4,
  parameter int               BUSY_BIT     = 1,
  parameter int               OSC_STOP_BIT = 3,
  parameter int               ADJ_BIT      = 0,
  parameter logic [3:0]       CTRL_BASE    = 4'h4,
  parameter logic [3:0]       ADDR_FIRST   = 4'd0,
  parameter logic [3:0]       ADDR_WDAY    = 4'd12,
  parameter logic [3:0]       ADDR_TINT    = 4'd13,
  parameter logic [3:0]       ADDR_CTRL    = 4'd14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initCmd,
  input  logic       getCmd,
  input  logic       setCmd,
  input  logic [7:0] setSec,
  input  logic [7:0] setMin,
  input  logic [7:0] setHour,
  input  logic [7:0] setDay,
  input  logic [7:0] setMon,
  input  logic [7:0] setYear,
  input  logic [3:0] setWday,
  output logic       regReq,
  output logic       regWrite,
  output logic [3:0] regAddr,
  output logic [3:0] regWdata,
  input  logic       regAck,
  input  logic [3:0] regRdata,
  output logic       chipEn,
  output logic [7:0] curSec,
  output logic [7:0] curMin,
  output logic [7:0] curHour,
  output logic [7:0] curDay,
  output logic [7:0] curMon,
  output logic [7:0] curYear,
  output logic [3:0] curWday,
  output logic       timeValid,
  output logic       errFlag,
  output logic       done
);
  dpStrobe_t                         strobe;
  logic                              lastStep;
  logic [FIELD_CNT-1:0][BYTE_W-1:0]  setFields;
  logic [FIELD_CNT-1:0][BYTE_W-1:0]  curFields;

  assign setFields = {setYear, setMon, setDay, setHour, setMin, setSec};
  assign {curYear, curMon, curDay, curHour, curMin, curSec} = curFields;

  rtc_seq_ctrl #(
    .RETRY_LIMIT(RETRY_LIMIT), .POLL_LIMIT(POLL_LIMIT), .GAP_CYCLES(GAP_CYCLES),
    .BUSY_BIT(BUSY_BIT), .OSC_STOP_BIT(OSC_STOP_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .getCmd(getCmd), .setCmd(setCmd),
    .regAck(regAck), .regRdata(regRdata), .lastStep(lastStep),
    .regReq(regReq), .regWrite(regWrite), .chipEn(chipEn), .done(done),
    .timeValid(timeValid), .errFlag(errFlag), .strobe(strobe)
  );

  rtc_seq_dpath #(
    .ADDR_FIRST(ADDR_FIRST), .ADDR_WDAY(ADDR_WDAY), .ADDR_TINT(ADDR_TINT),
    .ADDR_CTRL(ADDR_CTRL), .CTRL_BASE(CTRL_BASE), .ADJ_BIT(ADJ_BIT)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setFields(setFields), .setWday(setWday),
    .regRdata(regRdata), .regAddr(regAddr), .regWdata(regWdata), .lastStep(lastStep),
    .curFields(curFields), .curWday(curWday)
  );

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata)));
endmodule

// File: tb/rtc_time_sequencer_test.sv
`timescale 1ns/1ps
module rtc_time_sequencer_test;
  localparam int GAP   = 3;
  localparam int POLL  = 12;
  localparam int RETRY = 10;
  localparam logic [3:0] A_CTRL = 4'd14, A_TINT = 4'd13, A_WDAY = 4'd12;
  localparam int K_GET = 0, K_SET = 1, K_INIT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic initCmd = 0, getCmd = 0, setCmd = 0;
  logic [7:0] setSec = 0, setMin = 0, setHour = 0, setDay = 0, setMon = 0, setYear = 0;
  logic [3:0] setWday = 0;
  logic regReq, regWrite, chipEn, timeValid, errFlag, done;
  logic [3:0] regAddr, regWdata, curWday;
  logic [7:0] curSec, curMin, curHour, curDay, curMon, curYear;
  logic regAck = 0;
  logic [3:0] regRdata = 0;

  always #10 clk = ~clk;

  rtc_time_sequencer #(.GAP_CYCLES(GAP), .POLL_LIMIT(POLL)) uut (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .getCmd(getCmd), .setCmd(setCmd),
    .setSec(setSec), .setMin(setMin), .setHour(setHour), .setDay(setDay), .setMon(setMon),
    .setYear(setYear), .setWday(setWday), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .chipEn(chipEn), .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .curMon(curMon), .curYear(curYear), .curWday(curWday), .timeValid(timeValid),
    .errFlag(errFlag), .done(done)
  );

  // ---------------- clock-chip model ----------------
  logic modelClr = 0;
  int   busyTarget = 0;
  bit   xstpTarget = 0;
  logic [3:0] mem [16];
  logic [3:0] logAddr [64];
  logic       logWr   [64];
  logic [3:0] logData [64];
  int logN, busyUsed, ceRises, doneCnt, holdErr, reqNoCe, ceAtDone, dly;
  bit xstpLive, armed, cePrev, prevReq, prevAck, prevWr;
  logic [3:0] prevAddr, prevWd;

  initial for (int i = 0; i < 16; i++) mem[i] = 4'd0;

  always @(posedge clk) begin
    if (modelClr) begin
      logN <= 0; busyUsed <= 0; ceRises <= 0; doneCnt <= 0; holdErr <= 0;
      reqNoCe <= 0; ceAtDone <= 0; xstpLive <= xstpTarget; armed <= 0;
    end else begin
      if (chipEn && !cePrev) ceRises <= ceRises + 1;
      if (done) begin doneCnt <= doneCnt + 1; if (chipEn) ceAtDone <= ceAtDone + 1; end
      if (regReq && !chipEn) reqNoCe <= reqNoCe + 1;
      if (prevReq && !prevAck &&
          (!regReq || regAddr != prevAddr || regWrite != prevWr || regWdata != prevWd))
        holdErr <= holdErr + 1;
    end
    cePrev <= chipEn; prevReq <= regReq; prevAck <= regAck;
    prevAddr <= regAddr; prevWr <= regWrite; prevWd <= regWdata;
    regAck <= 1'b0;
    if (regReq && !regAck) begin
      if (dly != 0) dly <= dly - 1;
      else begin
        regAck <= 1'b1;
        dly <= int'($urandom % 3);
        if (logN < 64) begin
          logAddr[logN] <= regAddr; logWr[logN] <= regWrite;
          logData[logN] <= regWrite ? regWdata : 4'd0;
        end
        logN <= logN + 1;
        if (regWrite) begin
          if (regAddr == A_CTRL) begin
            armed <= 1'b1;
            if (regWdata[0]) xstpLive <= 1'b0;
          end else mem[regAddr] <= regWdata;
        end else if (regAddr == A_CTRL) begin
          regRdata <= {xstpLive, 1'b1, (armed && busyUsed < busyTarget), 1'b0};
          if (armed && busyUsed < busyTarget) busyUsed <= busyUsed + 1;
          if (regAddr == A_CTRL && !(xstpLive == 1'b0 && 1'b0)) armed <= armed;
        end else regRdata <= mem[regAddr];
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  logic [3:0] expAddr [64];
  logic       expWr   [64];
  logic [3:0] expData [64];
  int expN;
  bit benchValid = 0;
  logic [7:0] storedT [6];
  logic [3:0] storedW = 0;
  logic [7:0] shownT [6];
  logic [3:0] shownW = 0;
  logic [7:0] newT [6];
  logic [3:0] newW;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [3:0] a, input logic w, input logic [3:0] d);
    expAddr[expN] = a; expWr[expN] = w; expData[expN] = d; expN++;
  endtask

  function automatic logic [3:0] nibOf(input int k);
    if (k == 12) return newW;
    return (k % 2) ? newT[k/2][7:4] : newT[k/2][3:0];
  endfunction

  task automatic chkOutputs(input string req);
    logic [7:0] act [6];
    act[0] = curSec; act[1] = curMin; act[2] = curHour;
    act[3] = curDay; act[4] = curMon; act[5] = curYear;
    for (int f = 0; f < 6; f++) chk(req, $sformatf("field %0d", f), act[f], shownT[f]);
    chk(req, "weekday", curWday, shownW);
  endtask

  task automatic doCmd(input string req, input int kind, input int busyT, input bit xstpT, input bit poke);
    int ceExp, gd, bad; bit fail, errExp, validExp;
    expN = 0; ceExp = 0; fail = 0; errExp = 0; validExp = benchValid;
    if (kind == K_SET) begin
      for (int f = 0; f < 6; f++) newT[f] = 8'($urandom);
      newW = 4'($urandom % 7);
      setSec = newT[0]; setMin = newT[1]; setHour = newT[2];
      setDay = newT[3]; setMon = newT[4]; setYear = newT[5]; setWday = newW;
    end
    if (kind == K_INIT) begin
      ceExp = 1;
      pushExp(A_CTRL, 0, 0);
      if (!xstpT) validExp = 1;
      else begin
        validExp = 0;
        pushExp(A_TINT, 1, 0);
        pushExp(A_CTRL, 1, 4'h5);
        for (int p = 0; p < POLL; p++) begin
          pushExp(A_CTRL, 0, 0);
          if (p >= busyT) break;
        end
        if (busyT >= POLL) errExp = 1; else pushExp(A_CTRL, 1, 4'h4);
      end
    end else if (!(kind == K_GET && !benchValid)) begin
      for (int a = 0; a < RETRY; a++) begin
        pushExp(A_CTRL, 1, 4'h4); pushExp(A_CTRL, 0, 0); ceExp++;
        if (a >= busyT) break;
      end
      fail = (busyT >= RETRY); errExp = fail;
      if (!fail) begin
        for (int k = 0; k < 13; k++)
          pushExp((k == 12) ? A_WDAY : 4'(k), (kind == K_SET), (kind == K_SET) ? nibOf(k) : 4'd0);
        if (kind == K_SET) validExp = 1;
      end
    end
    @(negedge clk);
    busyTarget = busyT; xstpTarget = xstpT; modelClr = 1;
    if (kind == K_GET) getCmd = 1; else if (kind == K_SET) setCmd = 1; else initCmd = 1;
    @(negedge clk);
    modelClr = 0; getCmd = 0; setCmd = 0; initCmd = 0;
    if (poke) begin
      repeat (12) @(negedge clk);
      getCmd = 1; @(negedge clk); getCmd = 0;
    end
    gd = 0;
    while (doneCnt == 0 && gd < 20000) begin @(negedge clk); gd++; end
    repeat (15) @(negedge clk);
    bad = (logN != expN) ? 1 : 0;
    for (int i = 0; i < expN && i < logN; i++)
      if (logAddr[i] != expAddr[i] || logWr[i] != expWr[i] || logData[i] != expData[i]) bad++;
    chk(req, "access sequence mismatches", bad, 0);
    chk("R3", "chip enable assertions", ceRises, ceExp);
    chk("R6", "done pulses", doneCnt, 1);
    chk("R6", "chip enable high at done", ceAtDone, 0);
    chk("R2", "requests without chip enable", reqNoCe, 0);
    chk("R12", "request hold violations", holdErr, 0);
    chk(req, "errFlag", errFlag, errExp);
    chk(req, "timeValid", timeValid, validExp);
    benchValid = validExp;
    if (kind == K_SET && !fail) begin
      for (int f = 0; f < 6; f++) storedT[f] = newT[f];
      storedW = newW;
    end
    if (kind == K_GET && !fail && ceExp != 0) begin
      for (int f = 0; f < 6; f++) shownT[f] = storedT[f];
      shownW = storedW;
    end
    chkOutputs(req);
  endtask

  bit wdogHit = 0;
  initial begin
    repeat (200000) @(posedge clk);
    wdogHit = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    for (int f = 0; f < 6; f++) begin storedT[f] = 0; shownT[f] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "chipEn", chipEn, 0);
    chk("R1", "regReq", regReq, 0);
    chk("R1", "done", done, 0);
    chk("R1", "timeValid", timeValid, 0);
    chk("R1", "errFlag", errFlag, 0);
    chkOutputs("R1");
    rstN = 1;
    repeat (2) @(negedge clk);
    doCmd("R7", K_GET, 0, 0, 0);          // suppressed get after reset
    doCmd("R9", K_INIT, 0, 0, 0);         // oscillator running
    doCmd("R4", K_GET, 0, 0, 0);          // reads zero time
    doCmd("R10", K_INIT, 3, 1, 0);        // oscillator stopped, 3 busy polls
    doCmd("R7", K_GET, 0, 0, 0);          // invalid again
    doCmd("R11", K_INIT, POLL, 1, 0);     // poll exhaustion
    doCmd("R10", K_INIT, 0, 1, 0);        // stopped, no busy
    for (int i = 0; i < 6; i++) begin
      doCmd("R5", K_SET, int'($urandom % 5), 0, 0);
      doCmd("R4", K_GET, int'($urandom % 5), 0, 0);
    end
    doCmd("R3", K_GET, RETRY - 1, 0, 0);  // success on last attempt
    doCmd("R3", K_GET, RETRY, 0, 0);      // exhausted
    doCmd("R8", K_SET, RETRY, 0, 0);      // failing set keeps old time and valid
    doCmd("R4", K_GET, 0, 0, 0);
    doCmd("R13", K_SET, 2, 0, 1);         // get pulse mid-set ignored
    doCmd("R4", K_GET, 1, 0, 0);
    doCmd("R10", K_INIT, 1, 1, 0);
    doCmd("R7", K_GET, 0, 0, 0);          // outputs keep last read values
    doCmd("R8", K_SET, 0, 0, 0);
    doCmd("R4", K_GET, 0, 0, 0);
    if (!wdogHit) begin
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule